// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects six interrupt sources (two external request pins, three timer overflow events and one serial-port flag), filters them through a master enable and one enable bit per source, and presents a single vectored request to a processor core. Each source carries one priority bit, which places it in a low or a high level. Inside a level, a fixed polling order picks the winner.

The core answers with a one-cycle acknowledge. The controller then marks the granted level as in service and clears the source flag where hardware clearing applies. A one-cycle return input later closes the most recent routine. While a level is in service, only a request of a strictly higher level can be granted, so a high-level routine may preempt a low-level one but never the reverse. Each external pin is active low and can be set to latch a falling edge or to follow a low level. Each pin passes through a two-flop synchronizer before it is used.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When bit 7 of `enable_reg` is 0, `irq_req` stays low whatever flags are pending.
- R2: A source may only be granted when its enable bit is 1. The bit positions are: 0 ext0, 1 timer0, 2 ext1, 3 timer1, 4 serial, 5 timer2. These positions are also the source indices reported on `irq_src` and the bit positions of `pend_flags`.
- R3: Among the eligible sources of one level, the source with the lowest index wins.
- R4: A 1 in `prio_reg` at a source's position puts that source in the high level (`irq_level`=1). Any eligible high-level source beats every low-level source. While the high level is in service, nothing is granted. While only the low level is in service, only high-level sources are granted.
- R5: `irq_vector` equals 0x0003 + 8 × `irq_src`.
- R6: With `ext_edge_mode[k]`=1, a falling edge on `ext_pin_n[k]` latches the request flag. The flag stays set after the pin returns high, and it clears when that source is acknowledged.
- R7: With `ext_edge_mode[k]`=0, the request flag follows the synchronized low level of the pin. An acknowledge does not clear it.
- R8: A one-cycle pulse on `tmr_ovf[j]` sets the timer's flag on the next clock edge. Timer0 is on j=0, timer1 on j=1 and timer2 on j=2. The flag clears when that source is acknowledged.
- R9: The serial flag mirrors `ser_flag` directly, and an acknowledge does not clear it.
- R10: `ret` clears the highest set bit of `in_service`. Bit 1 is the high level and bit 0 is the low level.
- R11: After reset, `irq_req`, `in_service` and `pend_flags` are all zero.
- R12: `ack` while `irq_req` is high sets the `in_service` bit of the granted level on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_reg | input | 8 | Bit 7 is the master enable; bits 5..0 are the per-source enables |
| prio_reg | input | 8 | Bits 5..0 are the per-source priorities (1 = high) |
| ext_edge_mode | input | 2 | Per-pin trigger type (1 = falling edge, 0 = low level) |
| ext_pin_n | input | 2 | Asynchronous active-low external request pins |
| tmr_ovf | input | 3 | Timer overflow pulses (timer0, timer1, timer2) |
| ser_flag | input | 1 | Serial receive/transmit flag, as a level |
| ack | input | 1 | Core accepts the presented request |
| ret | input | 1 | Core finished the current routine |
| irq_req | output | 1 | A request is presented |
| irq_src | output | 3 | Index of the granted source |
| irq_level | output | 1 | Priority level of the granted source |
| irq_vector | output | 16 | Entry address of the granted source |
| in_service | output | 2 | Levels currently in service |
| pend_flags | output | 6 | Request flags per source index |

## Verification
The assertions check on every cycle that:
- the master mask holds;
- only enabled sources are granted;
- no grant breaks the nesting rule against the in-service levels;
- the vector's low bits and the acknowledge-to-in-service push are consistent;
- a return pops the high level first;
- an acknowledged timer flag clears.

The polling order within a level, the edge latching and synchronizer delay of the external pins, and the different clearing rules for level-mode pins and the serial flag are shown only by the bench's scenarios. The bench also tracks `in_service` through random acknowledge and return sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC  = 6;
  localparam int N_EXT  = 2;
  localparam int N_TMR  = 3;
  localparam int IDX_W  = 3;
  localparam int SER_SLOT = 4;

  // Source index owned by external pin k: ext0 -> 0, ext1 -> 2
  function automatic int ext_slot(input int k);
    return 2 * k;
  endfunction

  // Source index owned by timer j: timer0 -> 1, timer1 -> 3, timer2 -> 5
  function automatic int tmr_slot(input int j);
    return (j == 2) ? 5 : 2 * j + 1;
  endfunction

  // Lowest set index of a request vector (fixed polling order)
  function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  // Entry address: base plus slot stride times index
  function automatic logic [15:0] vec_addr(input logic [IDX_W-1:0] idx,
                                           input logic [15:0] base,
                                           input int stride_log2);
    return base + (16'(idx) << stride_log2);
  endfunction
endpackage

// File: rtl/irq_ext_input.sv
module irq_ext_input #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic clr,
  output logic req
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   pin_s;
  logic                   fall_seen;

  assign pin_s     = sync_q[SYNC_STAGES-1];
  assign fall_seen = prev_q & ~pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= pin_s;
      if (!edge_mode)     flag_q <= 1'b0;
      else if (fall_seen) flag_q <= 1'b1;
      else if (clr)       flag_q <= 1'b0;
    end
  end

  assign req = edge_mode ? flag_q : ~pin_s;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic [N_SRC-1:0] pend,
  input  logic [7:0]       enable_reg,
  input  logic [7:0]       prio_reg,
  input  logic [1:0]       in_service,
  output logic             grant,
  output logic [IDX_W-1:0] grant_idx,
  output logic             grant_lvl
);
  logic [N_SRC-1:0] eligible, hi_set, lo_set;
  logic             hi_ok, lo_ok;

  assign eligible = pend & enable_reg[N_SRC-1:0] & {N_SRC{enable_reg[7]}};
  assign hi_set   = eligible & prio_reg[N_SRC-1:0];
  assign lo_set   = eligible & ~prio_reg[N_SRC-1:0];
  assign hi_ok    = (|hi_set) & ~in_service[1];
  assign lo_ok    = (|lo_set) & (in_service == 2'b00);

  always_comb begin
    grant     = 1'b0;
    grant_idx = '0;
    grant_lvl = 1'b0;
    if (hi_ok) begin
      grant     = 1'b1;
      grant_idx = first_set(hi_set);
      grant_lvl = 1'b1;
    end else if (lo_ok) begin
      grant     = 1'b1;
      grant_idx = first_set(lo_set);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter logic [15:0] VEC_BASE    = 16'h0003,
  parameter int          VEC_STRIDE_LOG2 = 3,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  enable_reg,
  input  logic [7:0]  prio_reg,
  input  logic [1:0]  ext_edge_mode,
  input  logic [1:0]  ext_pin_n,
  input  logic [2:0]  tmr_ovf,
  input  logic        ser_flag,
  input  logic        ack,
  input  logic        ret,
  output logic        irq_req,
  output logic [2:0]  irq_src,
  output logic        irq_level,
  output logic [15:0] irq_vector,
  output logic [1:0]  in_service,
  output logic [5:0]  pend_flags
);
  logic [N_SRC-1:0] pend;
  logic [N_SRC-1:0] clr_slot;
  logic             grant_take;
  logic [1:0]       isv_q, isv_popped, isv_next;

  assign grant_take = ack & irq_req;

  generate
    for (genvar s = 0; s < N_SRC; s++) begin : g_clr
      assign clr_slot[s] = grant_take && (irq_src == IDX_W'(s));
    end

    for (genvar k = 0; k < N_EXT; k++) begin : g_ext
      irq_ext_input #(.SYNC_STAGES(SYNC_STAGES)) ext_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (ext_pin_n[k]),
        .edge_mode (ext_edge_mode[k]),
        .clr       (clr_slot[ext_slot(k)]),
        .req       (pend[ext_slot(k)])
      );
    end

    for (genvar j = 0; j < N_TMR; j++) begin : g_tmr
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (tmr_ovf[j])             flag_q <= 1'b1;
        else if (clr_slot[tmr_slot(j)])  flag_q <= 1'b0;
      end
      assign pend[tmr_slot(j)] = flag_q;
    end
  endgenerate

  assign pend[SER_SLOT] = ser_flag;

  irq_arbiter arb_i (
    .pend       (pend),
    .enable_reg (enable_reg),
    .prio_reg   (prio_reg),
    .in_service (isv_q),
    .grant      (irq_req),
    .grant_idx  (irq_src),
    .grant_lvl  (irq_level)
  );

  assign isv_popped = !ret ? isv_q : (isv_q[1] ? {1'b0, isv_q[0]} : 2'b00);
  assign isv_next   = isv_popped | (grant_take ? (irq_level ? 2'b10 : 2'b01) : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isv_q <= 2'b00;
    else        isv_q <= isv_next;
  end

  assign in_service = isv_q;
  assign pend_flags = pend;
  assign irq_vector = vec_addr(irq_src, VEC_BASE, VEC_STRIDE_LOG2);
endmodule

// File: rtl/irq_prio_checker.sv
module irq_prio_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  enable_reg,
  input logic [2:0]  tmr_ovf,
  input logic        ack,
  input logic        ret,
  input logic        irq_req,
  input logic [2:0]  irq_src,
  input logic        irq_level,
  input logic [15:0] irq_vector,
  input logic [1:0]  in_service,
  input logic [5:0]  pend_flags,
  input logic        grant_take
);
  assert_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_reg[7] |-> !irq_req);

  assert_src_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> enable_reg[irq_src] && pend_flags[irq_src]);

  assert_no_nest_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !in_service[1]);

  assert_no_nest_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_level) |-> in_service == 2'b00);

  assert_vector_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> irq_vector[2:0] == 3'd3 && irq_vector[15:6] == 10'd0);

  assert_push_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_take && !ret) |=> in_service[$past(irq_level)]);

  assert_timer_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_take && irq_src == 3'd1 && !tmr_ovf[0]) |=> !pend_flags[1]);

  assert_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && in_service[1]) |=> !in_service[1] && in_service[0] == $past(in_service[0]));
endmodule

bind irq_prio_ctrl irq_prio_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable_reg (enable_reg),
  .tmr_ovf    (tmr_ovf),
  .ack        (ack),
  .ret        (ret),
  .irq_req    (irq_req),
  .irq_src    (irq_src),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .in_service (in_service),
  .pend_flags (pend_flags),
  .grant_take (grant_take)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  enable_reg = 8'h00;
  logic [7:0]  prio_reg = 8'h00;
  logic [1:0]  ext_edge_mode = 2'b00;
  logic [1:0]  ext_pin_n = 2'b11;
  logic [2:0]  tmr_ovf = 3'b000;
  logic        ser_flag = 1'b0;
  logic        ack = 1'b0;
  logic        ret = 1'b0;
  logic        irq_req;
  logic [2:0]  irq_src;
  logic        irq_level;
  logic [15:0] irq_vector;
  logic [1:0]  in_service;
  logic [5:0]  pend_flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_prio_ctrl dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("[TB] FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic do_ack();  ack = 1'b1; tick(); ack = 1'b0; endtask
  task automatic do_ret();  ret = 1'b1; tick(); ret = 1'b0; endtask
  task automatic pulse(input logic [2:0] m); tmr_ovf = m; tick(); tmr_ovf = 3'b000; endtask

  // Bench model of the grant: high level first, lowest index first
  function automatic logic [4:0] expect_grant(input logic [5:0] p, input logic [7:0] en,
                                              input logic [7:0] pr, input logic [1:0] isv);
    // returns {req, level, src[2:0]}
    if (!en[7]) return 5'b0;
    if (!isv[1])
      for (int i = 0; i < 6; i++)
        if (p[i] && en[i] && pr[i]) return {1'b1, 1'b1, 3'(i)};
    if (isv == 2'b00)
      for (int i = 0; i < 6; i++)
        if (p[i] && en[i] && !pr[i]) return {1'b1, 1'b0, 3'(i)};
    return 5'b0;
  endfunction

  function automatic logic [15:0] expect_vec(input logic [2:0] s);
    return 16'd3 + 16'd8 * 16'(s);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fails++;
      $display("[TB] FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] isv_m;
    logic [4:0] g;
    void'($urandom(32'h1D5EED));
    tick(2);
    // R11 reset state
    chk("R11 req", irq_req, 0);
    chk("R11 isv", in_service, 0);
    chk("R11 pend", pend_flags, 0);
    rst_n = 1'b1;
    tick();

    // R1 master mask
    enable_reg = 8'h3F;
    pulse(3'b001);
    chk("R8 timer0 flag set", pend_flags[1], 1);
    chk("R1 masked", irq_req, 0);
    enable_reg = 8'hBF;
    #1;
    chk("R1 unmasked req", irq_req, 1);
    chk("R5 vector timer0", irq_vector, 16'h000B);
    // R2 per-source enable
    enable_reg = 8'h81;
    #1;
    chk("R2 timer0 disabled", irq_req, 0);
    enable_reg = 8'hBF;
    #1;
    // R8 clear on ack, R12 push
    do_ack();
    chk("R8 timer0 cleared", pend_flags[1], 0);
    chk("R12 low pushed", in_service, 2'b01);
    do_ret();
    chk("R10 pop low", in_service, 2'b00);

    // R3 order within a level
    pulse(3'b111);
    chk("R3 first timer0", irq_src, 1);
    do_ack(); do_ret();
    chk("R3 then timer1", irq_src, 3);
    do_ack(); do_ret();
    chk("R3 then timer2", irq_src, 5);
    chk("R5 vector timer2", irq_vector, 16'h002B);
    do_ack(); do_ret();

    // R4 priority and nesting
    prio_reg = 8'h20;
    pulse(3'b101);
    chk("R4 high wins", {irq_level, irq_src}, {1'b1, 3'd5});
    do_ack();
    chk("R4 high in service", in_service, 2'b10);
    chk("R4 low blocked under high", irq_req, 0);
    do_ret();
    chk("R4 low after ret", irq_src, 1);
    do_ack();
    chk("R4 low in service", in_service, 2'b01);
    pulse(3'b100);
    chk("R4 preempt req", {irq_req, irq_level}, 2'b11);
    do_ack();
    chk("R12 both levels", in_service, 2'b11);
    do_ret();
    chk("R10 pops high first", in_service, 2'b01);
    do_ret();
    chk("R10 pops low", in_service, 2'b00);
    prio_reg = 8'h00;

    // R6 edge-triggered ext0
    ext_edge_mode = 2'b01;
    tick();
    ext_pin_n[0] = 1'b0;
    tick(4);
    ext_pin_n[0] = 1'b1;
    tick(4);
    chk("R6 edge latched", pend_flags[0], 1);
    chk("R6 ext0 vector", irq_vector, 16'h0003);
    do_ack();
    chk("R6 cleared on ack", pend_flags[0], 0);
    do_ret();

    // R7 level-triggered ext1
    ext_pin_n[1] = 1'b0;
    tick(4);
    chk("R7 level pending", pend_flags[2], 1);
    chk("R7 src ext1", irq_src, 2);
    do_ack();
    chk("R7 not cleared by ack", pend_flags[2], 1);
    do_ret();
    ext_pin_n[1] = 1'b1;
    tick(4);
    chk("R7 follows pin", pend_flags[2], 0);

    // R9 serial
    ser_flag = 1'b1;
    #1;
    chk("R9 serial src", irq_src, 4);
    do_ack();
    chk("R9 not cleared", pend_flags[4], 1);
    do_ret();
    ser_flag = 1'b0;
    #1;
    chk("R9 mirrors input", pend_flags[4], 0);

    // Random phase: R2 R3 R4 R5 R10 R12
    ext_edge_mode = 2'b00;
    isv_m = in_service;
    for (int c = 0; c < 3000; c++) begin
      enable_reg = 8'($urandom) | ((($urandom % 4) != 0) ? 8'h80 : 8'h00);
      prio_reg   = 8'($urandom);
      ser_flag   = ($urandom % 3) == 0;
      #1;
      g = expect_grant(pend_flags, enable_reg, prio_reg, isv_m);
      chk("R4 rand req", irq_req, g[4]);
      if (g[4]) begin
        chk("R3 rand src", {irq_level, irq_src}, g[3:0]);
        chk("R5 rand vec", irq_vector, expect_vec(g[2:0]));
      end
      case ($urandom % 4)
        0: ack = 1'b1;
        1: ret = 1'b1;
        default: ;
      endcase
      tmr_ovf = 3'($urandom) & 3'($urandom);
      tick();
      if (ret) isv_m = isv_m[1] ? {1'b0, isv_m[0]} : 2'b00;
      if (ack && g[4]) isv_m = isv_m | (g[3] ? 2'b10 : 2'b01);
      ack = 1'b0; ret = 1'b0; tmr_ovf = 3'b000;
      chk("R10 rand isv", in_service, isv_m);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule